// File: doc/BRIEF.md
# Timer-Based Capture/Compare Unit with Period-Reset Event

This unit watches the count of a shared 16-bit timer. In one of four capture modes it records the timer value into its 16-bit holding register when a chosen transition arrives on an input pin. The pin passes through a two-flop synchronizer before edge detection. In the two compare modes it raises a single-cycle event when the holding register equals the timer. In the period-reset variant of compare, that event also drives a clear request back to the timer. The holding register then sets the timer's period.

The clear request is a dedicated signal. It is separate from any timer overflow path, so the timer's own overflow flag and interrupt are never disturbed by it. A software write to the timer that lands in the same cycle as a clear beats the clear. The unit keeps one sticky interrupt flag for itself. The clear is issued only while the timer reports that it runs synchronously from the internal clock.

Top module: `ccp_timebase_unit`

## Requirements
- R1: After reset, ccpReg is 0, and ccpFlag, cmpEvent and timerClear are all 0.
- R2: mode encodes the function: 0 off, 1 capture on every falling pin edge, 2 capture on every rising pin edge, 3 capture on every 4th rising edge, 4 capture on every 16th rising edge, 5 compare, 6 compare with period reset, 7 off. If capPin holds a new level at clock edge k and held the old level at edge k-1, then in capture modes ccpReg loads the timerCount present at edge k+2.
- R3: In modes 3 and 4, rising pin edges are counted. Every 4th (mode 3) or 16th (mode 4) counted edge causes a capture. The count restarts from zero whenever mode changes, and an edge seen in the cycle of the change is not counted.
- R4: In modes 5 and 6, if timerCount equals ccpReg at an edge where it did not equal it at the previous edge (or the unit was not in a compare mode then), cmpEvent is high for exactly the following cycle. A timer that holds the matching value gives only one event.
- R5: In mode 6, timerClear is high in the cycle where cmpEvent is high, provided timerSync is 1 and timerWrite is 0 in that cycle. In every other mode timerClear stays 0. A timer that obeys it runs 0 to ccpReg+1 and then returns to 0.
- R6: timerWrite high in a cycle suppresses timerClear in that cycle, so the written value wins.
- R7: With timerSync at 0, the period-reset clear is not issued, but cmpEvent still fires.
- R8: ccpFlag is set by every capture and every cmpEvent, and it stays set until flagClear is high at an edge. A set in the same edge as a clear wins.
- R9: regWrite loads regWrData into ccpReg at the next edge. A capture at that same edge takes priority. In modes 0 and 7, pin edges do not change ccpReg and no events are produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Function select (see R2) |
| capPin | input | 1 | Asynchronous capture pin |
| timerCount | input | 16 | Current count of the shared timer |
| timerWrite | input | 1 | Software is writing the timer this cycle |
| timerSync | input | 1 | Timer runs synchronously from the internal clock |
| regWrite | input | 1 | Software load of the holding register |
| regWrData | input | 16 | Value for the holding register load |
| flagClear | input | 1 | Software clear of the interrupt flag |
| ccpReg | output | 16 | Holding register (capture value or compare value) |
| cmpEvent | output | 1 | One-cycle compare event |
| timerClear | output | 1 | Request to clear the timer |
| ccpFlag | output | 1 | Sticky interrupt flag |

## Verification
The bench holds the timer at the matching value for several cycles. A design that compares without edge detection would fire repeatedly and set its flag over and over. It lines up a software timer write exactly with the period-reset event; a design that lets the clear win would reset the timer and lose the written value. It also runs the period-reset mode with the timer marked asynchronous, and switches between the two prescaled capture modes. A wrong prescaler would capture on the wrong edge count or carry a stale partial count across a mode change. The capture timing is checked through the two-flop synchronizer delay: a design with an extra or missing stage records a timer value off by one.

// File: rtl/ccp_pkg.sv
package ccp_pkg;

  typedef enum logic [2:0] {
    MODE_OFF        = 3'd0,
    MODE_CAP_FALL   = 3'd1,
    MODE_CAP_RISE   = 3'd2,
    MODE_CAP_RISE4  = 3'd3,
    MODE_CAP_RISE16 = 3'd4,
    MODE_CMP_EVENT  = 3'd5,
    MODE_CMP_PERIOD = 3'd6,
    MODE_RSVD       = 3'd7
  } ccpMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;
    logic swLoad;
  } ccpStrobe_t;

endpackage

// File: rtl/ccp_edge_prescale.sv
module ccp_edge_prescale #(
  parameter int PRE_SMALL = 4,
  parameter int PRE_LARGE = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic riseEdge,
  input  logic selLarge,
  output logic fire
);
  localparam int CW = (PRE_LARGE > 1) ? $clog2(PRE_LARGE) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;

  assign limit = selLarge ? CW'(PRE_LARGE - 1) : CW'(PRE_SMALL - 1);
  assign fire  = riseEdge & ~clr & (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (riseEdge) begin
      if (cnt == limit) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  // R3: a prescaled capture always restarts the edge count
  p_restart_after_fire_r3: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> (cnt == '0));

endmodule

// File: rtl/ccp_datapath.sv
module ccp_datapath
  import ccp_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          capPin,
  input  logic [TW-1:0] timerCount,
  input  logic [TW-1:0] regWrData,
  input  ccpStrobe_t    strb,
  output logic          pinSync,
  output logic          timerEq,
  output logic [TW-1:0] ccpReg
);

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncFf;
      always_ff @(posedge clk) begin
        if (!rstN) syncFf <= 1'b0;
        else       syncFf <= capPin;
      end
      assign pinSync = syncFf;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncChain;
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], capPin};
      end
      assign pinSync = syncChain[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ccpReg <= '0;
    end else if (strb.capLoad) begin
      ccpReg <= timerCount;
    end else if (strb.swLoad) begin
      ccpReg <= regWrData;
    end
  end

  assign timerEq = (timerCount == ccpReg);

  // R2: a capture strobe records the timer value of that cycle
  p_capture_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.capLoad |=> (ccpReg == $past(timerCount)));

  // R9: with no strobe the holding register keeps its value
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.capLoad && !strb.swLoad) |=> $stable(ccpReg));

endmodule

// File: rtl/ccp_control.sv
module ccp_control
  import ccp_pkg::*;
#(
  parameter int PRE_SMALL = 4,
  parameter int PRE_LARGE = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  ccpMode_e   mode,
  input  logic       pinSync,
  input  logic       timerEq,
  input  logic       regWrite,
  input  logic       flagClear,
  input  logic       timerWrite,
  input  logic       timerSync,
  output ccpStrobe_t strb,
  output logic       cmpEvent,
  output logic       timerClear,
  output logic       ccpFlag
);

  logic     pinPrev;
  logic     riseEdge;
  logic     fallEdge;
  ccpMode_e modePrev;
  logic     modeChange;
  logic     preFire;
  logic     capEvent;
  logic     isCompare;
  logic     matchNow;
  logic     matchPrev;
  logic     matchRise;

  assign riseEdge   = pinSync & ~pinPrev;
  assign fallEdge   = ~pinSync & pinPrev;
  assign modeChange = (mode != modePrev);

  ccp_edge_prescale #(
    .PRE_SMALL (PRE_SMALL),
    .PRE_LARGE (PRE_LARGE)
  ) u_prescale (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (modeChange),
    .riseEdge (riseEdge),
    .selLarge (mode == MODE_CAP_RISE16),
    .fire     (preFire)
  );

  always_comb begin
    unique case (mode)
      MODE_CAP_FALL:   capEvent = fallEdge;
      MODE_CAP_RISE:   capEvent = riseEdge;
      MODE_CAP_RISE4,
      MODE_CAP_RISE16: capEvent = preFire;
      default:         capEvent = 1'b0;
    endcase
  end

  assign isCompare = (mode == MODE_CMP_EVENT) || (mode == MODE_CMP_PERIOD);
  assign matchNow  = isCompare & timerEq;
  assign matchRise = matchNow & ~matchPrev;

  always_comb begin
    strb.capLoad = capEvent;
    strb.swLoad  = regWrite & ~capEvent;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pinPrev   <= 1'b0;
      modePrev  <= MODE_OFF;
      matchPrev <= 1'b0;
      cmpEvent  <= 1'b0;
      ccpFlag   <= 1'b0;
    end else begin
      pinPrev   <= pinSync;
      modePrev  <= mode;
      matchPrev <= matchNow;
      cmpEvent  <= matchRise;
      ccpFlag   <= (ccpFlag & ~flagClear) | capEvent | matchRise;
    end
  end

  // write collision wins over the period clear; async timer gets no clear
  assign timerClear = cmpEvent & (mode == MODE_CMP_PERIOD) & timerSync & ~timerWrite;

  // R4: the compare event never lasts more than one cycle
  p_event_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvent |=> !cmpEvent);

  // R8: flag is sticky until cleared
  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ccpFlag && !flagClear) |=> ccpFlag);

  // R8: every compare event is accompanied by a set flag
  p_flag_on_event_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvent |-> ccpFlag);

endmodule

// File: rtl/ccp_timebase_unit.sv
module ccp_timebase_unit
  import ccp_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PRE_SMALL   = 4,
  parameter int PRE_LARGE   = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [2:0]    mode,
  input  logic          capPin,
  input  logic [TW-1:0] timerCount,
  input  logic          timerWrite,
  input  logic          timerSync,
  input  logic          regWrite,
  input  logic [TW-1:0] regWrData,
  input  logic          flagClear,
  output logic [TW-1:0] ccpReg,
  output logic          cmpEvent,
  output logic          timerClear,
  output logic          ccpFlag
);

  ccpStrobe_t strb;
  logic       pinSync;
  logic       timerEq;

  ccp_control #(
    .PRE_SMALL (PRE_SMALL),
    .PRE_LARGE (PRE_LARGE)
  ) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .mode       (ccpMode_e'(mode)),
    .pinSync    (pinSync),
    .timerEq    (timerEq),
    .regWrite   (regWrite),
    .flagClear  (flagClear),
    .timerWrite (timerWrite),
    .timerSync  (timerSync),
    .strb       (strb),
    .cmpEvent   (cmpEvent),
    .timerClear (timerClear),
    .ccpFlag    (ccpFlag)
  );

  ccp_datapath #(
    .TW          (TW),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .capPin     (capPin),
    .timerCount (timerCount),
    .regWrData  (regWrData),
    .strb       (strb),
    .pinSync    (pinSync),
    .timerEq    (timerEq),
    .ccpReg     (ccpReg)
  );

endmodule

// File: tb/ccp_timebase_unit_tb.sv
`timescale 1ns/1ps
module ccp_timebase_unit_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic        capPin = 1'b0;
  logic [15:0] tCount = 16'd0;
  logic        timerWrite = 1'b0;
  logic [15:0] wrVal = 16'd0;
  logic        timerRun = 1'b0;
  logic        timerSync = 1'b1;
  logic        regWrite = 1'b0;
  logic [15:0] regWrData = 16'd0;
  logic        flagClear = 1'b0;
  logic [15:0] ccpReg;
  logic        cmpEvent, timerClear, ccpFlag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  bit          hist[$];
  logic [15:0] mReg;
  bit          mFlag, mEvent, mEqPrev;
  int          mCnt;
  logic [2:0]  mPrevMode;
  int          clearSeen;
  int          eventSeen;
  int          maxCount;

  always #10 clk = ~clk;

  ccp_timebase_unit u_dut (
    .clk(clk), .rstN(rstN), .mode(mode), .capPin(capPin),
    .timerCount(tCount), .timerWrite(timerWrite), .timerSync(timerSync),
    .regWrite(regWrite), .regWrData(regWrData), .flagClear(flagClear),
    .ccpReg(ccpReg), .cmpEvent(cmpEvent), .timerClear(timerClear), .ccpFlag(ccpFlag)
  );

  function automatic bit expClear();
    return mEvent && (mode == 3'd6) && timerSync && !timerWrite;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // reference model and timer environment
  always @(posedge clk) begin
    if (!rstN) begin
      hist = '{0, 0, 0};
      mReg = 0; mFlag = 0; mEvent = 0; mEqPrev = 0; mCnt = 0; mPrevMode = 0;
      tCount <= 16'd0;
    end else begin
      bit rise, fall, cap, eq, mrise, chg, fire;
      int lim;
      rise = hist[$-1] && !hist[$-2];
      fall = !hist[$-1] && hist[$-2];
      chg = (mode != mPrevMode);
      lim = (mode == 3'd4) ? 15 : 3;
      fire = 0;
      if (chg) mCnt = 0;
      else if (rise) begin
        if (mCnt == lim) begin fire = 1; mCnt = 0; end
        else mCnt++;
      end
      case (mode)
        3'd1: cap = fall;
        3'd2: cap = rise;
        3'd3, 3'd4: cap = fire;
        default: cap = 0;
      endcase
      eq = ((mode == 3'd5) || (mode == 3'd6)) && (tCount == mReg);
      mrise = eq && !mEqPrev;
      if (timerWrite) tCount <= wrVal;
      else if (expClear()) tCount <= 16'd0;
      else if (timerRun) tCount <= tCount + 16'd1;
      if (timerClear) clearSeen++;
      if (cmpEvent) eventSeen++;
      if (int'(tCount) > maxCount) maxCount = int'(tCount);
      mFlag = (mFlag && !flagClear) || cap || mrise;
      if (cap) mReg = tCount;
      else if (regWrite) mReg = regWrData;
      mEqPrev = eq;
      mEvent = mrise;
      mPrevMode = mode;
      hist.push_back(capPin);
      if (hist.size() > 8) void'(hist.pop_front());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      string rt, ct;
      rt = (mode == 3'd3 || mode == 3'd4) ? "R3" : (mode == 3'd1 || mode == 3'd2) ? "R2" : "R9";
      ct = timerWrite ? "R6" : (!timerSync ? "R7" : "R5");
      check(rt, "ccpReg", ccpReg, mReg);
      check("R4", "cmpEvent", cmpEvent, mEvent);
      check(ct, "timerClear", timerClear, expClear());
      check("R8", "ccpFlag", ccpFlag, mFlag);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulsePin(input int rises, input int gap);
    for (int i = 0; i < rises; i++) begin
      capPin = 1'b1; step(gap);
      capPin = 1'b0; step(gap);
    end
  endtask

  task automatic setMode(input logic [2:0] m);
    mode = m; step(2);
  endtask

  task automatic writeReg(input logic [15:0] v);
    regWrite = 1'b1; regWrData = v; step(1);
    regWrite = 1'b0; step(1);
  endtask

  task automatic finish();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hang expected=done");
    finish();
  end

  initial begin
    logic [15:0] held;
    step(3);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1", "ccpReg reset", ccpReg, 0);
    check("R1", "ccpFlag reset", ccpFlag, 0);
    check("R1", "cmpEvent reset", cmpEvent, 0);
    check("R1", "timerClear reset", timerClear, 0);
    step(1);

    timerRun = 1'b1;
    // R2 rising and falling captures
    setMode(3'd2); pulsePin(4, 5);
    setMode(3'd1); pulsePin(4, 7);
    check("R8", "flag set after captures", ccpFlag, 1);
    flagClear = 1'b1; step(1); flagClear = 1'b0; step(1);
    check("R8", "flag cleared", ccpFlag, 0);

    // R9 off mode ignores pin
    setMode(3'd0);
    held = ccpReg;
    pulsePin(3, 4);
    check("R9", "off mode keeps ccpReg", ccpReg, held);
    check("R9", "off mode no flag", ccpFlag, 0);
    setMode(3'd7); pulsePin(2, 4);
    check("R9", "reserved mode keeps ccpReg", ccpReg, held);

    // R3 prescaled captures, and a mode switch between them
    setMode(3'd3);
    pulsePin(3, 3);
    check("R3", "no capture before 4th rise", ccpReg, held);
    pulsePin(6, 3);
    setMode(3'd4); pulsePin(10, 3);
    setMode(3'd3); pulsePin(2, 3);
    setMode(3'd4); pulsePin(35, 3);

    // R9 software write
    setMode(3'd0);
    writeReg(16'd40);
    check("R9", "regWrite loads", ccpReg, 40);

    // R4 compare with a held timer value
    timerRun = 1'b0;
    setMode(3'd5);
    eventSeen = 0;
    timerWrite = 1'b1; wrVal = 16'd40; step(1); timerWrite = 1'b0;
    step(8);
    check("R4", "single event for held match", eventSeen, 1);
    timerRun = 1'b1;
    timerWrite = 1'b1; wrVal = 16'd30; step(1); timerWrite = 1'b0;
    step(20);

    // R5 period reset
    setMode(3'd0);
    writeReg(16'd20);
    timerWrite = 1'b1; wrVal = 16'd0; step(1); timerWrite = 1'b0;
    setMode(3'd6);
    clearSeen = 0; maxCount = 0;
    step(100);
    check("R5", "timer max equals period+1", maxCount, 21);
    check("R5", "clears in 100 cycles", (clearSeen >= 4) ? 1 : 0, 1);

    // R6 collision: write held across the event
    timerRun = 1'b0;
    clearSeen = 0; eventSeen = 0;
    timerWrite = 1'b1; wrVal = 16'd20; step(4); timerWrite = 1'b0;
    check("R6", "no clear under write", clearSeen, 0);
    check("R6", "event still seen", eventSeen, 1);
    check("R6", "written value kept", tCount, 20);
    timerRun = 1'b1;
    step(10);

    // R7 asynchronous timer: no clear
    timerSync = 1'b0;
    timerWrite = 1'b1; wrVal = 16'd10; step(1); timerWrite = 1'b0;
    clearSeen = 0; eventSeen = 0;
    step(20);
    check("R7", "no clear while async", clearSeen, 0);
    check("R7", "event while async", eventSeen, 1);
    timerSync = 1'b1;

    // R5 compare-only mode issues no clear
    setMode(3'd5);
    timerWrite = 1'b1; wrVal = 16'd10; step(1); timerWrite = 1'b0;
    clearSeen = 0;
    step(20);
    check("R5", "mode 5 never clears", clearSeen, 0);

    // R8 set wins over clear, then clear
    flagClear = 1'b1; step(3); flagClear = 1'b0; step(1);
    check("R8", "flag clear", ccpFlag, 0);
    step(2);
    finish();
  end

endmodule